// File: doc/BRIEF.md
# Two-Cycle Search Command Capture Unit

This unit accepts a search request that the host spreads over two back-to-back clock cycles, with a command-valid strobe held high in both. The first cycle, A, carries the global mask pair selector and two upper address bits to report on a hit. The second cycle, B, carries the comparand pair selector and the result register selector. The 68-bit data bus is sampled in both cycles, and the two samples are stored together as one 136-bit word in the chosen comparand pair.

The stored word is then compared against a small on-chip table of 68-bit entries in single-width mode. The even mask of the chosen pair applies to the cycle-A half and the odd mask applies to the cycle-B half. A mask bit of 1 makes that bit position match unconditionally. The lowest-indexed matching entry wins. The hit flag and the match address go into the host-chosen result register, and a one-cycle done pulse marks the write.

A command that breaks the two-cycle protocol raises a one-cycle protocol-error pulse and is discarded. The table and the mask registers are loaded through a simple write port. The result registers are read through an asynchronous read port.

The control state machine has four states:
- ST_IDLE waits for cycle A.
- ST_HAVE_A has cycle A latched and expects cycle B.
- ST_MATCH registers the compare result.
- ST_POST writes the result register and raises done.

It has these transitions:
- ST_IDLE to ST_HAVE_A on a valid cycle A.
- ST_HAVE_A to ST_MATCH on a valid cycle B.
- ST_HAVE_A to ST_IDLE on a broken cycle B (error).
- ST_MATCH to ST_POST unconditionally.
- ST_POST to ST_IDLE unconditionally.
- ST_IDLE stays in ST_IDLE on anything else, including the error case where cmd[2]=1.

Top module: `srch_cmd_unit`

## Requirements
- R1: After reset, done and prot_err are low, and every result register reads rd_hit=0 and rd_addr=0. The table and all mask registers reset to zero.
- R2: A search is accepted only in this case: cmd_valid=1 and cmd[1:0]=2'b10 on two consecutive rising edges (A then B), with cmd[2]=0 at A, while the unit is idle. The result register is written at the second edge after B, and done is high for exactly the one cycle that follows that edge. A new cycle A is accepted from the third edge after B onward.
- R3: The result goes to the register whose index is cmd[8:6] sampled at B. Asynchronous read: rd_idx selects the register shown on rd_hit/rd_addr.
- R4: On a hit, the register holds rd_hit=1 and rd_addr={cmd[8:7] sampled at A, matching entry index}, with the entry index in the low bits.
- R5: When several entries match, the lowest entry index is reported.
- R6: The mask pair index is cmd[5:3] sampled at A. Mask register 2*p masks the cycle-A data and mask register 2*p+1 masks the cycle-B data. A mask bit of 1 forces that bit to match. The comparand pair index is cmd[5:2] at B and has no effect on the result.
- R7: On a miss, the selected result register becomes rd_hit=0 and rd_addr=0, replacing any earlier contents.
- R8: A cycle A with cmd[2]=1 raises prot_err for the one cycle after that edge. No search starts, and no result register changes.
- R9: If the edge after cycle A lacks cmd_valid=1 with cmd[1:0]=2'b10, the command is discarded. prot_err is high for the cycle after that edge, no done follows, and the unit is idle again at the next edge.
- R10: Table and mask writes take effect at the rising edge where wr_en=1. wr_mask=0 writes table entry wr_addr, and wr_mask=1 writes mask register wr_addr. While idle, cmd_valid=0 or any code other than 2'b10 has no effect on done, prot_err or the result registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 9 | Command bits; field meaning depends on cycle A or B |
| dq | input | DW | Compare data, sampled in cycles A and B |
| wr_en | input | 1 | Write strobe for table or mask bank |
| wr_mask | input | 1 | 0 selects the table, 1 selects the mask bank |
| wr_addr | input | WAW | Entry or mask register index |
| wr_data | input | DW | Write data |
| rd_idx | input | 3 | Result register read select |
| rd_hit | output | 1 | Hit flag of the selected result register |
| rd_addr | output | 2+EAW | Match address of the selected result register |
| done | output | 1 | One-cycle pulse when a result register is written |
| prot_err | output | 1 | One-cycle pulse on a protocol violation |

## Verification
The bench builds the unit with its default widths: 68-bit data and 16 table entries, giving a 4-bit entry index and a 6-bit match address. With these values, all eight mask pairs, all sixteen comparand pairs and all eight result registers can be addressed. A duplicated entry exposes the lowest-index priority, and masks that cover the low data byte let a key with altered low bits still hit. The read select walks through every result register on successive cycles, so that a write to the wrong register, or a result left behind after an error, shows up at once.

// File: rtl/srch_pkg.sv
package srch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HAVE_A,
        ST_MATCH,
        ST_POST
    } state_t;

    localparam logic [1:0] CODE_SEARCH = 2'b10;
endpackage

// File: rtl/srch_mask_bank.sv
module srch_mask_bank #(
    parameter int DW = 68
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    pair_sel,
    output logic [DW-1:0] m_even,
    output logic [DW-1:0] m_odd
);
    localparam int NREG = 16;

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    assign m_even = regs[{pair_sel, 1'b0}];
    assign m_odd  = regs[{pair_sel, 1'b1}];
endmodule

// File: rtl/srch_match.sv
module srch_match #(
    parameter int DW      = 68,
    parameter int ENTRIES = 16,
    localparam int EAW    = $clog2(ENTRIES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [EAW-1:0] wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [DW-1:0]  key_lo,
    input  logic [DW-1:0]  key_hi,
    input  logic [DW-1:0]  mask_lo,
    input  logic [DW-1:0]  mask_hi,
    output logic           hit,
    output logic [EAW-1:0] idx
);
    logic [DW-1:0]      table_q [ENTRIES];
    logic [ENTRIES-1:0] mv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) table_q[i] <= '0;
        end else if (wr_en) begin
            table_q[wr_addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign mv[g] = (((table_q[g] ^ key_lo) & ~mask_lo) == '0) &&
                       (((table_q[g] ^ key_hi) & ~mask_hi) == '0);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (mv[i]) begin
                hit = 1'b1;
                idx = EAW'(i);
            end
        end
    end
endmodule

// File: rtl/srch_result_rf.sv
module srch_result_rf #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    w_idx,
    input  logic          w_hit,
    input  logic [AW-1:0] w_addr,
    input  logic [2:0]    rd_idx,
    output logic          rd_hit,
    output logic [AW-1:0] rd_addr
);
    localparam int NRES = 8;

    logic          hit_q  [NRES];
    logic [AW-1:0] addr_q [NRES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NRES; i++) begin
                hit_q[i]  <= 1'b0;
                addr_q[i] <= '0;
            end
        end else if (we) begin
            hit_q[w_idx]  <= w_hit;
            addr_q[w_idx] <= w_addr;
        end
    end

    assign rd_hit  = hit_q[rd_idx];
    assign rd_addr = addr_q[rd_idx];
endmodule

// File: rtl/srch_cmd_unit.sv
module srch_cmd_unit #(
    parameter int DW      = 68,
    parameter int ENTRIES = 16,
    localparam int EAW    = $clog2(ENTRIES),
    localparam int WAW    = (EAW > 4) ? EAW : 4,
    localparam int RAW    = 2 + EAW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [8:0]     cmd,
    input  logic [DW-1:0]  dq,
    input  logic           wr_en,
    input  logic           wr_mask,
    input  logic [WAW-1:0] wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [2:0]     rd_idx,
    output logic           rd_hit,
    output logic [RAW-1:0] rd_addr,
    output logic           done,
    output logic           prot_err
);
    import srch_pkg::*;

    localparam int NCMP = 16;

    state_t         state, state_nx;
    logic           is_search;
    logic [DW-1:0]  a_data;
    logic [2:0]     gmr_q;
    logic [1:0]     up_q;
    logic [3:0]     cmp_q;
    logic [2:0]     res_q;
    logic           hit_q;
    logic [EAW-1:0] idx_q;
    logic [DW-1:0]  cmp_lo [NCMP];
    logic [DW-1:0]  cmp_hi [NCMP];
    logic [DW-1:0]  m_even, m_odd;
    logic           m_hit;
    logic [EAW-1:0] m_idx;

    assign is_search = cmd_valid && (cmd[1:0] == CODE_SEARCH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (is_search && !cmd[2]) state_nx = ST_HAVE_A;
            ST_HAVE_A: state_nx = is_search ? ST_MATCH : ST_IDLE;
            ST_MATCH:  state_nx = ST_POST;
            ST_POST:   state_nx = ST_IDLE;
        endcase
    end

    // outputs and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_data   <= '0;
            gmr_q    <= '0;
            up_q     <= '0;
            cmp_q    <= '0;
            res_q    <= '0;
            hit_q    <= 1'b0;
            idx_q    <= '0;
            done     <= 1'b0;
            prot_err <= 1'b0;
            for (int i = 0; i < NCMP; i++) begin
                cmp_lo[i] <= '0;
                cmp_hi[i] <= '0;
            end
        end else begin
            done     <= 1'b0;
            prot_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (is_search) begin
                        if (cmd[2]) begin
                            prot_err <= 1'b1;
                        end else begin
                            a_data <= dq;
                            gmr_q  <= cmd[5:3];
                            up_q   <= cmd[8:7];
                        end
                    end
                end
                ST_HAVE_A: begin
                    if (is_search) begin
                        cmp_lo[cmd[5:2]] <= a_data;
                        cmp_hi[cmd[5:2]] <= dq;
                        cmp_q <= cmd[5:2];
                        res_q <= cmd[8:6];
                    end else begin
                        prot_err <= 1'b1;
                    end
                end
                ST_MATCH: begin
                    hit_q <= m_hit;
                    idx_q <= m_idx;
                end
                ST_POST: done <= 1'b1;
            endcase
        end
    end

    srch_mask_bank #(.DW(DW)) u_masks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en && wr_mask),
        .wr_addr  (wr_addr[3:0]),
        .wr_data  (wr_data),
        .pair_sel (gmr_q),
        .m_even   (m_even),
        .m_odd    (m_odd)
    );

    srch_match #(.DW(DW), .ENTRIES(ENTRIES)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && !wr_mask),
        .wr_addr (wr_addr[EAW-1:0]),
        .wr_data (wr_data),
        .key_lo  (cmp_lo[cmp_q]),
        .key_hi  (cmp_hi[cmp_q]),
        .mask_lo (m_even),
        .mask_hi (m_odd),
        .hit     (m_hit),
        .idx     (m_idx)
    );

    srch_result_rf #(.AW(RAW)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (state == ST_POST),
        .w_idx   (res_q),
        .w_hit   (hit_q),
        .w_addr  (hit_q ? {up_q, idx_q} : '0),
        .rd_idx  (rd_idx),
        .rd_hit  (rd_hit),
        .rd_addr (rd_addr)
    );
endmodule

// File: rtl/srch_cmd_unit_chk.sv
module srch_cmd_unit_chk #(
    parameter int RAW = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [8:0]       cmd,
    input srch_pkg::state_t state,
    input logic             done,
    input logic             prot_err,
    input logic             rd_hit,
    input logic [RAW-1:0]   rd_addr
);
    import srch_pkg::*;

    logic srch;
    assign srch = cmd_valid && (cmd[1:0] == CODE_SEARCH);

    // R2
    done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state == ST_HAVE_A && srch, 3));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    miss_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (rd_addr == '0));

    // R8
    bad_a_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && srch && cmd[2]) |=> (prot_err && state == ST_IDLE));

    // R9
    bad_b_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HAVE_A && !srch) |=> (prot_err && state == ST_IDLE));

    // R9
    err_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && prot_err));
endmodule

bind srch_cmd_unit srch_cmd_unit_chk #(.RAW(RAW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .state     (state),
    .done      (done),
    .prot_err  (prot_err),
    .rd_hit    (rd_hit),
    .rd_addr   (rd_addr)
);

// File: tb/srch_cmd_unit_tb.sv
module srch_cmd_unit_tb;
    localparam int DW  = 68;
    localparam int ENT = 16;
    localparam int EAW = 4;
    localparam int RAW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [8:0]     cmd = '0;
    logic [DW-1:0]  dq = '0;
    logic           wr_en = 1'b0;
    logic           wr_mask = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [2:0]     rd_idx = '0;
    logic           rd_hit;
    logic [RAW-1:0] rd_addr;
    logic           done;
    logic           prot_err;

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    srch_cmd_unit #(.DW(DW), .ENTRIES(ENT)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .dq(dq),
        .wr_en(wr_en), .wr_mask(wr_mask), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_hit(rd_hit), .rd_addr(rd_addr),
        .done(done), .prot_err(prot_err)
    );

    // behavioural reference model
    logic [DW-1:0] mtab [ENT];
    logic [DW-1:0] mmask [16];
    bit            mres_hit [8];
    int            mres_addr [8];
    bit            exp_done = 0, exp_err = 0;
    int            ecnt = 0;
    bit            job = 0, have_a = 0, busy;
    int            job_b, jg, jup, jres, jidx;
    bit            jhit;
    logic [DW-1:0] ja, jb;

    initial begin
        for (int i = 0; i < ENT; i++) mtab[i] = '0;
        for (int i = 0; i < 16; i++) mmask[i] = '0;
        for (int i = 0; i < 8; i++) begin mres_hit[i] = 0; mres_addr[i] = 0; end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_done = 0; exp_err = 0; job = 0; have_a = 0;
        end else begin
            ecnt++;
            exp_done = 0;
            exp_err  = 0;
            busy = job;
            if (job && ecnt == job_b + 1) begin
                jhit = 0; jidx = 0;
                for (int e = 0; e < ENT; e++) begin
                    if (!jhit && ((mtab[e] ^ ja) & ~mmask[2*jg]) == '0 &&
                                 ((mtab[e] ^ jb) & ~mmask[2*jg+1]) == '0) begin
                        jhit = 1; jidx = e;
                    end
                end
            end
            if (job && ecnt == job_b + 2) begin
                mres_hit[jres]  = jhit;
                mres_addr[jres] = jhit ? (jup * ENT + jidx) : 0;
                exp_done = 1;
                job = 0;
            end
            if (!busy) begin
                if (have_a) begin
                    have_a = 0;
                    if (cmd_valid && cmd[1:0] == 2'b10) begin
                        job = 1; job_b = ecnt; jb = dq; jres = int'(cmd[8:6]);
                    end else begin
                        exp_err = 1;
                    end
                end else if (cmd_valid && cmd[1:0] == 2'b10) begin
                    if (cmd[2]) exp_err = 1;
                    else begin
                        have_a = 1; ja = dq; jg = int'(cmd[5:3]); jup = int'(cmd[8:7]);
                    end
                end
            end
            if (wr_en) begin
                if (wr_mask) mmask[wr_addr] = wr_data;
                else         mtab[wr_addr[EAW-1:0]] = wr_data;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        vectors++;
        if (done !== exp_done) begin
            miscompares++;
            $display("FAIL %s done: actual %b expected %b", cur_req, done, exp_done);
        end
        if (prot_err !== exp_err) begin
            miscompares++;
            $display("FAIL %s prot_err: actual %b expected %b", cur_req, prot_err, exp_err);
        end
        if (rd_hit !== mres_hit[rd_idx] || rd_addr !== RAW'(mres_addr[rd_idx])) begin
            miscompares++;
            $display("FAIL %s result[%0d]: actual hit=%b addr=%0d expected hit=%b addr=%0d",
                     cur_req, rd_idx, rd_hit, rd_addr, mres_hit[rd_idx], mres_addr[rd_idx]);
        end
        rd_idx = rd_idx + 3'd1;
    end

    function automatic logic [DW-1:0] entry_val(int e);
        return (DW'(e + 1) << 40) | DW'(68'hABCD);
    endfunction

    task automatic idle(int n);
        cmd_valid = 0; cmd = '0; wr_en = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit to_mask, int addr, logic [DW-1:0] data);
        wr_en = 1; wr_mask = to_mask; wr_addr = 4'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic search(logic [DW-1:0] a, logic [DW-1:0] b, int gmr, int up,
                          int cmpi, int res, int gap);
        cmd_valid = 1; dq = a;
        cmd = {2'(up), 1'b0, 3'(gmr), 1'b0, 2'b10};
        @(negedge clk);
        dq = b;
        cmd = {3'(res), 4'(cmpi), 2'b10};
        @(negedge clk);
        idle(gap);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle(10);
        cur_req = "R10";
        for (int e = 0; e < ENT; e++) wr(0, e, entry_val(e));
        idle(2);
        cur_req = "R2 R3 R4";
        search(entry_val(5), entry_val(5), 0, 2, 3, 3, 10);
        cur_req = "R3 R4 R6";
        search(entry_val(12), entry_val(12), 4, 1, 15, 6, 10);
        cur_req = "R5";
        wr(0, 9, entry_val(2));
        idle(1);
        search(entry_val(2), entry_val(2), 0, 3, 0, 0, 10);
        cur_req = "R6";
        wr(1, 10, 68'hFF);
        wr(1, 11, 68'hFF);
        idle(1);
        search(entry_val(7) ^ 68'h5A, entry_val(7) ^ 68'h5A, 5, 1, 7, 1, 10);
        cur_req = "R6 R7";
        search(entry_val(7) ^ 68'h5A, entry_val(7) ^ 68'h5A, 0, 1, 7, 1, 10);
        cur_req = "R7";
        search(68'h3_1111_2222_3333_4444, 68'h3_1111_2222_3333_4444, 0, 2, 8, 3, 10);
        cur_req = "R8";
        cmd_valid = 1; dq = entry_val(4); cmd = {2'd1, 1'b0, 3'd0, 1'b1, 2'b10};
        @(negedge clk);
        idle(8);
        cur_req = "R9";
        cmd_valid = 1; dq = entry_val(4); cmd = {2'd1, 1'b0, 3'd0, 1'b0, 2'b10};
        @(negedge clk);
        idle(6);
        cmd_valid = 1; cmd = {2'd1, 1'b0, 3'd0, 1'b0, 2'b10};
        @(negedge clk);
        cmd = {3'd2, 4'd1, 2'b01};
        @(negedge clk);
        idle(6);
        cur_req = "R10";
        cmd_valid = 1; cmd = {3'd5, 4'd2, 2'b11}; dq = entry_val(1);
        repeat (3) @(negedge clk);
        cmd = {3'd5, 4'd2, 2'b00};
        repeat (3) @(negedge clk);
        cmd_valid = 0; cmd = {3'd5, 4'd2, 2'b10};
        repeat (3) @(negedge clk);
        idle(8);
        cur_req = "R2";
        search(entry_val(4), entry_val(4), 0, 0, 2, 5, 2);
        search(entry_val(11), entry_val(11), 0, 3, 9, 7, 0);
        search(entry_val(0), entry_val(0), 0, 2, 4, 4, 12);
        cur_req = "R4";
        search(entry_val(15), entry_val(15), 2, 3, 1, 2, 12);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule